// File: doc/BRIEF.md
# Hybrid Bimodal/Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The bimodal component is indexed by the branch address alone. The gshare component is indexed by the branch address XORed with a global record of recent outcomes. A third table of counters, indexed by branch address, picks which component supplies the final answer. All three predictions for the presented fetch address appear combinationally in the same cycle.

When a branch resolves, the pipeline returns the branch address, the real outcome, and the two component predictions it kept from fetch. The block then trains the bimodal and gshare counters toward the outcome. It trains the chooser only when the two components disagreed. It also shifts the outcome into the global history. History changes at resolve and at no other time. Address inputs carry the word address of the branch, already stripped of its byte-offset bits, so the low `IDX_W` bits form the table index directly.

Top module: `hybrid_bp`

## Requirements
- R1: After reset, every bimodal and gshare counter holds 2'b10 (weakly taken), every chooser counter holds 2'b01 (weakly bimodal) and the history is all zeros. Any fetch address therefore yields `pred_bim_o`=1, `pred_gsh_o`=1 and `pred_taken_o`=1.
- R2: Each counter is 2 bits. Values 2'b10 and 2'b11 predict taken; 2'b00 and 2'b01 predict not-taken. A trained counter steps by one toward 2'b11 on taken and toward 2'b00 on not-taken, and it holds at either end.
- R3: The bimodal entry used for a prediction or for training is the one selected by the address bits [IDX_W-1:0].
- R4: The gshare entry is selected by the address bits [IDX_W-1:0] XOR the global history, with the history zero-extended when it is shorter than the index. Training uses the history as it stands in the resolve cycle, before that cycle's shift.
- R5: On each resolve the history shifts left by one. The outcome enters at bit 0, with 1 meaning taken and 0 meaning not-taken.
- R6: The chooser entry is selected by the address bits [IDX_W-1:0]. Its values 2'b10 and 2'b11 select gshare and its values 2'b00 and 2'b01 select bimodal.
- R7: Chooser training happens only when the two component predictions differ. In that case the chooser steps toward 2'b11 when gshare matched the outcome and toward 2'b00 when bimodal matched, saturating at both ends.
- R8: All three predictions are combinational functions of the fetch address and the current state. A fetch that hits an entry being trained in the same cycle sees the value from before the update.
- R9: While `res_valid_i` is low, no counter and no history bit changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | IDX_W | Low word-address bits of the fetch PC |
| pred_taken_o | output | 1 | Final direction prediction |
| pred_bim_o | output | 1 | Bimodal component prediction |
| pred_gsh_o | output | 1 | Gshare component prediction |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | IDX_W | Low word-address bits of the resolving branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_bim_i | input | 1 | Bimodal prediction kept from fetch |
| res_gsh_i | input | 1 | Gshare prediction kept from fetch |

## Verification
All three predictions are due in the cycle the fetch address is applied, with no register in their path. The bench drives inputs after the falling edge and samples one time unit later, still before the next rising edge. A resolve applied in cycle N changes counters and history at the rising edge that closes cycle N. Its effect is therefore expected only from cycle N+1 onward. The reference model commits each update right after that edge and never earlier. The same-cycle collision case is checked by reading the trained entry in the cycle of its update, where the old value is expected, and again in the following cycle, where the new value is expected.

// File: rtl/hybrid_bp_pkg.sv
package hybrid_bp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_SNT = 2'b00;
  localparam ctr2_t CTR_WNT = 2'b01;
  localparam ctr2_t CTR_WT  = 2'b10;
  localparam ctr2_t CTR_ST  = 2'b11;

  // saturating one-step move
  function automatic ctr2_t ctr_step(ctr2_t cur, logic up);
    ctr2_t nxt;
    if (up) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import hybrid_bp_pkg::*;
#(
  parameter int    IDX_W   = 8,
  parameter ctr2_t RST_VAL = CTR_WT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr2_t            rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_step(mem_q[wr_idx_i], wr_up_i);
    end
  end

  // read sees pre-update contents
  assign rd_ctr_o = mem_q[rd_idx_i];

endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   hist_ext;

  assign hist_ext = {hist_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= hist_ext[HIST_W-1:0];
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/bp_index_hash.sv
module bp_index_hash #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic [IDX_W-1:0]  pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  gsh_idx_o
);

  logic [IDX_W-1:0] hist_fit;

  generate
    if (HIST_W >= IDX_W) begin : g_trunc
      assign hist_fit = hist_i[IDX_W-1:0];
    end else begin : g_pad
      assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist_i};
    end
  endgenerate

  assign gsh_idx_o = pc_i ^ hist_fit;

endmodule

// File: rtl/hybrid_bp.sv
module hybrid_bp
  import hybrid_bp_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] fetch_pc_i,
  output logic             pred_taken_o,
  output logic             pred_bim_o,
  output logic             pred_gsh_o,
  input  logic             res_valid_i,
  input  logic [IDX_W-1:0] res_pc_i,
  input  logic             res_taken_i,
  input  logic             res_bim_i,
  input  logic             res_gsh_i
);

  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  fetch_gidx, res_gidx;
  ctr2_t             bim_ctr, gsh_ctr, cho_ctr;
  logic              cho_wr_en, cho_up;

  bp_hist_reg #(.HIST_W(HIST_W)) u_ghr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(res_valid_i),
    .bit_i     (res_taken_i),
    .hist_o    (ghr_q)
  );

  bp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_fetch (
    .pc_i     (fetch_pc_i),
    .hist_i   (ghr_q),
    .gsh_idx_o(fetch_gidx)
  );

  bp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_res (
    .pc_i     (res_pc_i),
    .hist_i   (ghr_q),
    .gsh_idx_o(res_gidx)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WT)) u_bim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(fetch_pc_i),
    .rd_ctr_o(bim_ctr),
    .wr_en_i (res_valid_i),
    .wr_idx_i(res_pc_i),
    .wr_up_i (res_taken_i)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WT)) u_gsh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(fetch_gidx),
    .rd_ctr_o(gsh_ctr),
    .wr_en_i (res_valid_i),
    .wr_idx_i(res_gidx),
    .wr_up_i (res_taken_i)
  );

  // chooser learns only on disagreement; up = toward gshare
  assign cho_wr_en = res_valid_i && (res_bim_i != res_gsh_i);
  assign cho_up    = (res_gsh_i == res_taken_i);

  bp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_cho (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(fetch_pc_i),
    .rd_ctr_o(cho_ctr),
    .wr_en_i (cho_wr_en),
    .wr_idx_i(res_pc_i),
    .wr_up_i (cho_up)
  );

  assign pred_bim_o   = bim_ctr[1];
  assign pred_gsh_o   = gsh_ctr[1];
  assign pred_taken_o = cho_ctr[1] ? pred_gsh_o : pred_bim_o;

endmodule

// File: rtl/hybrid_bp_chk.sv
module hybrid_bp_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic [HIST_W-1:0] ghr_i,
  input logic              pred_taken_o,
  input logic              pred_bim_o,
  input logic              pred_gsh_o
);

  // R5
  ghr_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> (ghr_i[0] == $past(res_taken_i)));

  // R9
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghr_i));

  // R6
  pred_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_bim_o == pred_gsh_o) |-> (pred_taken_o == pred_bim_o));

  // R6
  pred_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_taken_o == pred_bim_o) || (pred_taken_o == pred_gsh_o));

endmodule

bind hybrid_bp hybrid_bp_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_taken_i (res_taken_i),
  .ghr_i       (ghr_q),
  .pred_taken_o(pred_taken_o),
  .pred_bim_o  (pred_bim_o),
  .pred_gsh_o  (pred_gsh_o)
);

// File: tb/hybrid_bp_test.sv
module hybrid_bp_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 8;
  localparam int HIST_W = 8;
  localparam int DEPTH  = 1 << IDX_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IDX_W-1:0] fetch_pc_i = '0;
  logic             pred_taken_o, pred_bim_o, pred_gsh_o;
  logic             res_valid_i = 1'b0;
  logic [IDX_W-1:0] res_pc_i = '0;
  logic             res_taken_i = 1'b0;
  logic             res_bim_i = 1'b0;
  logic             res_gsh_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [1:0]        bim_m [DEPTH];
  logic [1:0]        gsh_m [DEPTH];
  logic [1:0]        cho_m [DEPTH];
  logic [HIST_W-1:0] ghr_m;

  hybrid_bp #(.IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
    .clk_i, .rst_ni, .fetch_pc_i, .pred_taken_o, .pred_bim_o, .pred_gsh_o,
    .res_valid_i, .res_pc_i, .res_taken_i, .res_bim_i, .res_gsh_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic logic [IDX_W-1:0] gidx(logic [IDX_W-1:0] pc);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < HIST_W && i < IDX_W; i++) h[i] = ghr_m[i];
    return pc ^ h;
  endfunction

  function automatic logic m_bim(logic [IDX_W-1:0] pc);
    return bim_m[pc][1];
  endfunction

  function automatic logic m_gsh(logic [IDX_W-1:0] pc);
    return gsh_m[gidx(pc)][1];
  endfunction

  function automatic logic m_final(logic [IDX_W-1:0] pc);
    return cho_m[pc][1] ? m_gsh(pc) : m_bim(pc);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      bim_m[i] = 2'b10;
      gsh_m[i] = 2'b10;
      cho_m[i] = 2'b01;
    end
    ghr_m = '0;
  endtask

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive, check outputs, then commit the model after the edge
  task automatic step(logic [IDX_W-1:0] pf, logic rv, logic [IDX_W-1:0] pr, logic tk,
                      bit do_check);
    logic eb, eg;
    logic [IDX_W-1:0] gi;
    @(negedge clk_i);
    eb = m_bim(pr);
    eg = m_gsh(pr);
    gi = gidx(pr);
    fetch_pc_i  = pf;
    res_valid_i = rv;
    res_pc_i    = pr;
    res_taken_i = tk;
    res_bim_i   = eb;
    res_gsh_i   = eg;
    #1;
    if (do_check) begin
      check_bit("R3", "pred_bim_o", pred_bim_o, m_bim(pf));
      check_bit("R4 R5", "pred_gsh_o", pred_gsh_o, m_gsh(pf));
      check_bit("R6 R7", "pred_taken_o", pred_taken_o, m_final(pf));
    end
    @(posedge clk_i);
    if (rv) begin
      bim_m[pr] = sat(bim_m[pr], tk);
      gsh_m[gi] = sat(gsh_m[gi], tk);
      if (eb != eg) cho_m[pr] = sat(cho_m[pr], eg == tk);
      ghr_m = {ghr_m[HIST_W-2:0], tk};
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state at several addresses
    foreach (fetch_pc_i[k]) begin end
    for (int p = 0; p < 4; p++) begin
      @(negedge clk_i);
      fetch_pc_i = IDX_W'(p * 61);
      #1;
      check_bit("R1", "pred_bim_o", pred_bim_o, 1'b1);
      check_bit("R1", "pred_gsh_o", pred_gsh_o, 1'b1);
      check_bit("R1", "pred_taken_o", pred_taken_o, 1'b1);
    end

    // R2 saturation on bimodal entry 5
    repeat (3) step(8'd5, 1'b1, 8'd5, 1'b1, 1'b0);
    step(8'd5, 1'b1, 8'd5, 1'b0, 1'b0);
    @(negedge clk_i); res_valid_i = 1'b0; fetch_pc_i = 8'd5; #1;
    check_bit("R2", "strong-taken after one not-taken", pred_bim_o, 1'b1);
    step(8'd5, 1'b1, 8'd5, 1'b0, 1'b0);
    @(negedge clk_i); res_valid_i = 1'b0; fetch_pc_i = 8'd5; #1;
    check_bit("R2", "weak-not-taken", pred_bim_o, 1'b0);
    repeat (3) step(8'd5, 1'b1, 8'd5, 1'b0, 1'b0);
    step(8'd5, 1'b1, 8'd5, 1'b1, 1'b0);
    @(negedge clk_i); res_valid_i = 1'b0; fetch_pc_i = 8'd5; #1;
    check_bit("R2", "floor holds, one taken stays not-taken", pred_bim_o, 1'b0);

    // R8 read during write on bimodal entry 9 (still 10)
    @(negedge clk_i);
    fetch_pc_i = 8'd9; res_pc_i = 8'd9; res_taken_i = 1'b0;
    res_bim_i = m_bim(8'd9); res_gsh_i = m_gsh(8'd9); res_valid_i = 1'b1;
    #1;
    check_bit("R8", "same-cycle read returns old", pred_bim_o, 1'b1);
    begin
      logic [IDX_W-1:0] gi;
      logic eb, eg;
      gi = gidx(8'd9); eb = m_bim(8'd9); eg = m_gsh(8'd9);
      @(posedge clk_i);
      bim_m[9] = sat(bim_m[9], 1'b0);
      gsh_m[gi] = sat(gsh_m[gi], 1'b0);
      if (eb != eg) cho_m[9] = sat(cho_m[9], eg == 1'b0);
      ghr_m = {ghr_m[HIST_W-2:0], 1'b0};
    end
    @(negedge clk_i); res_valid_i = 1'b0; #1;
    check_bit("R8", "next-cycle read returns new", pred_bim_o, 1'b0);

    // R9 idle resolve inputs with taken outcome must not train entry 9
    repeat (4) step(8'd9, 1'b0, 8'd9, 1'b1, 1'b1);
    check_bit("R9", "entry unchanged with valid low", pred_bim_o, 1'b0);

    // random mix with biased outcomes; model checks every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [IDX_W-1:0] pf, pr;
      logic rv, tk;
      pf = ($urandom % 4 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 12);
      pr = ($urandom % 4 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 12);
      rv = ($urandom % 4) != 0;
      tk = (pr[0] ? (($urandom % 8) != 0) : (n % 4 != 3));
      step(pf, rv, pr, tk, 1'b1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule